// File: doc/BRIEF.md
# Capture/Reload Sixteen-Bit Timer

This block is a sixteen-bit counter paired with a sixteen-bit capture/reload register. A byte-wide register port lets a processor read and write it. On each step the counter moves by one. A step is either an internal tick, which comes once every 12 clocks or once every 6 clocks in fast mode, or a falling edge on the external count pin. A separate trigger pin gives the block an external event. Depending on the mode bits, that event copies the running count into the capture register or reloads the counter from it.

Two baud-clock select bits turn the block into a rate generator for a serial port. While either bit is set, the counter reloads on every overflow and emits a one-clock overflow pulse. In this mode it raises no overflow flag and takes no action on the trigger pin. A down-count option makes the trigger pin's level choose the count direction. The overflow flag and the external-event flag are combined into one interrupt output. Software is the only thing that clears either flag.

Top module: `cr_timer16`

Register map, addressed by `addr`:
- 0 is control. Bit 7 is the overflow flag, bit 6 the external flag, bit 5 the receive baud select and bit 4 the transmit baud select. Bit 3 is trigger enable, bit 2 is run, bit 1 selects the count source (1 means count pin edges) and bit 0 selects capture (1) or reload (0).
- 1 is mode. Bit 0 is down-count enable and bit 1 is fast tick. All other bits read 0.
- 2 and 3 are the count low and high bytes.
- 4 and 5 are the capture/reload low and high bytes.

## Requirements
- R1: After reset, every register reads 0 and `irq` is 0.
- R2: When run=1 and source=1, each falling edge on `cnt_pin` increments the count by one. When run=0, the count holds.
- R3: When run=1 and source=0, the count advances once every 12 clocks after run is set. With mode bit 1 set, it advances once every 6 clocks.
- R4: In capture mode (control bit 0 = 1, no baud select), an up step from 0xFFFF wraps the count to 0x0000 and sets control bit 7.
- R5: In reload mode (control bit 0 = 0), an up step from 0xFFFF loads the capture/reload value and sets control bit 7.
- R6: With trigger enable=1 and capture mode, a falling edge on `trig_pin` copies the count into the capture register and sets control bit 6.
- R7: With trigger enable=1 and reload mode, a falling edge on `trig_pin` loads the count from the capture/reload register and sets control bit 6.
- R8: With trigger enable=0, `trig_pin` edges change neither the count, the capture register nor the flags.
- R9: While control bit 4 or bit 5 is set, overflow reloads the count, pulses `baud_tick` for one clock and leaves bit 7 clear, and trigger edges are ignored. `tx_use_t2` follows bit 4 and `rx_use_t2` follows bit 5.
- R10: With mode bit 0 set and no baud select, a low `trig_pin` makes the count step down. A down step taken when the count equals the capture/reload value loads 0xFFFF and sets bit 7. A high `trig_pin` makes the count step up, with reload on overflow.
- R11: `irq` is high while control bit 7 or bit 6 is set. Both flags stay set until software writes the control register.
- R12: A write to a count byte takes effect on the next clock and overrides any step taken in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Read data byte (combinational from addr) |
| cnt_pin | input | 1 | External count input |
| trig_pin | input | 1 | External trigger / direction input |
| irq | output | 1 | Interrupt request |
| baud_tick | output | 1 | One-clock overflow pulse in baud mode |
| tx_use_t2 | output | 1 | Transmit clock taken from this timer |
| rx_use_t2 | output | 1 | Receive clock taken from this timer |

## Verification
The hardest case to reach is an overflow or trigger event landing on an exact count, because the synchronizer puts three clocks of delay between a pin and the counter. To make every step countable, the stimulus table runs the counter from `cnt_pin` edges with each pin level held for three clocks. Near-wrap values are preloaded while the counter is stopped, and the trigger edge is applied only after the last count pulse. This reaches wrap, reload, capture and baud-mode suppression on known values. Down counting holds `trig_pin` low before the first pulse so that the direction is settled.

// File: rtl/cr_timer16_pkg.sv
package cr_timer16_pkg;

    typedef enum logic [2:0] {
        RA_CTRL   = 3'd0,
        RA_MODE   = 3'd1,
        RA_CNT_LO = 3'd2,
        RA_CNT_HI = 3'd3,
        RA_CAP_LO = 3'd4,
        RA_CAP_HI = 3'd5
    } reg_addr_e;

    typedef struct packed {
        logic ovf_flag;
        logic ext_flag;
        logic rx_baud;
        logic tx_baud;
        logic trig_en;
        logic run;
        logic src_pin;
        logic cap_sel;
    } ctrl_t;

    typedef struct packed {
        logic fast;
        logic down_en;
    } mode_t;

endpackage

// File: rtl/cr_edge_sync.sv
module cr_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic level,
    output logic fall
);
    typedef struct packed {
        logic [STAGES-1:0] sh;
        logic              last;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = STAGES - 1; i > 0; i--) begin
            st_d.sh[i] = st_q.sh[i-1];
        end
        st_d.sh[0] = din;
        st_d.last  = st_q.sh[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign level = st_q.sh[STAGES-1];
    assign fall  = st_q.last & ~st_q.sh[STAGES-1];
endmodule

// File: rtl/cr_prescale.sv
module cr_prescale #(
    parameter int DIV_SLOW = 12,
    parameter int DIV_FAST = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic fast,
    output logic tick
);
    localparam int PW = (DIV_SLOW > 1) ? $clog2(DIV_SLOW) : 1;
    localparam logic [PW-1:0] LIM_SLOW = PW'(DIV_SLOW - 1);
    localparam logic [PW-1:0] LIM_FAST = PW'(DIV_FAST - 1);

    logic [PW-1:0] psc_d, psc_q;
    logic [PW-1:0] lim;

    always_comb begin
        lim   = fast ? LIM_FAST : LIM_SLOW;
        tick  = 1'b0;
        psc_d = psc_q;
        if (!en) begin
            psc_d = '0;
        end else if (psc_q >= lim) begin
            tick  = 1'b1;
            psc_d = '0;
        end else begin
            psc_d = psc_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) psc_q <= '0;
        else        psc_q <= psc_d;
    end
endmodule

// File: rtl/cr_count_core.sv
module cr_count_core #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    input  logic         cap_sel,
    input  logic         trig_en,
    input  logic         baud,
    input  logic         down_en,
    input  logic         dir_up,
    input  logic         trig_fall,
    input  logic         wr_cnt_lo,
    input  logic         wr_cnt_hi,
    input  logic         wr_cap_lo,
    input  logic         wr_cap_hi,
    input  logic [7:0]   wdata,
    output logic [W-1:0] cnt,
    output logic [W-1:0] cap,
    output logic         ovf_set,
    output logic         ext_set,
    output logic         baud_pulse
);
    localparam logic [W-1:0] ALL1 = {W{1'b1}};

    typedef struct packed {
        logic [W-1:0] cnt;
        logic [W-1:0] cap;
    } st_t;

    st_t  st_d, st_q;
    logic updown;
    logic trig_act;
    logic wrap_hit;
    logic reload_on_wrap;

    always_comb begin
        st_d           = st_q;
        updown         = down_en & ~baud;
        trig_act       = trig_en & ~baud & ~updown & trig_fall;
        reload_on_wrap = baud | updown | ~cap_sel;
        wrap_hit       = 1'b0;
        ovf_set        = 1'b0;
        ext_set        = 1'b0;
        baud_pulse     = 1'b0;

        if (wr_cap_lo) st_d.cap[7:0]   = wdata;
        if (wr_cap_hi) st_d.cap[W-1:8] = wdata;

        if (step) begin
            if (updown && !dir_up) begin
                if (st_q.cnt == st_q.cap) begin
                    st_d.cnt = ALL1;
                    wrap_hit = 1'b1;
                end else begin
                    st_d.cnt = st_q.cnt - 1'b1;
                end
            end else if (st_q.cnt == ALL1) begin
                wrap_hit = 1'b1;
                st_d.cnt = reload_on_wrap ? st_q.cap : '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end

        if (wrap_hit) begin
            if (baud) baud_pulse = 1'b1;
            else      ovf_set    = 1'b1;
        end

        if (trig_act) begin
            ext_set = 1'b1;
            if (cap_sel) st_d.cap = st_q.cnt;
            else         st_d.cnt = st_q.cap;
        end

        if (wr_cnt_lo) st_d.cnt[7:0]   = wdata;
        if (wr_cnt_hi) st_d.cnt[W-1:8] = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt = st_q.cnt;
    assign cap = st_q.cap;
endmodule

// File: rtl/cr_timer16.sv
module cr_timer16
    import cr_timer16_pkg::*;
#(
    parameter int W           = 16,
    parameter int DIV_SLOW    = 12,
    parameter int DIV_FAST    = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [2:0] addr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    input  logic       cnt_pin,
    input  logic       trig_pin,
    output logic       irq,
    output logic       baud_tick,
    output logic       tx_use_t2,
    output logic       rx_use_t2
);
    typedef struct packed {
        ctrl_t ctrl;
        mode_t mode;
    } regs_t;

    regs_t     regs_d, regs_q;
    reg_addr_e ra;
    logic      wr_ctrl, wr_mode, wr_cnt_lo, wr_cnt_hi, wr_cap_lo, wr_cap_hi;
    logic      cnt_fall, cnt_lvl;
    logic      trig_fall, trig_lvl;
    logic      psc_tick;
    logic      cnt_step;
    logic      baud_mode;
    logic      ovf_set, ext_set;
    logic [W-1:0] cnt_val, cap_val;

    assign ra        = reg_addr_e'(addr);
    assign wr_ctrl   = wr_en && (ra == RA_CTRL);
    assign wr_mode   = wr_en && (ra == RA_MODE);
    assign wr_cnt_lo = wr_en && (ra == RA_CNT_LO);
    assign wr_cnt_hi = wr_en && (ra == RA_CNT_HI);
    assign wr_cap_lo = wr_en && (ra == RA_CAP_LO);
    assign wr_cap_hi = wr_en && (ra == RA_CAP_HI);

    cr_edge_sync #(.STAGES(SYNC_STAGES)) u_cnt_sync (
        .clk(clk), .rst_n(rst_n), .din(cnt_pin), .level(cnt_lvl), .fall(cnt_fall)
    );

    cr_edge_sync #(.STAGES(SYNC_STAGES)) u_trig_sync (
        .clk(clk), .rst_n(rst_n), .din(trig_pin), .level(trig_lvl), .fall(trig_fall)
    );

    cr_prescale #(.DIV_SLOW(DIV_SLOW), .DIV_FAST(DIV_FAST)) u_psc (
        .clk(clk), .rst_n(rst_n),
        .en(regs_q.ctrl.run & ~regs_q.ctrl.src_pin),
        .fast(regs_q.mode.fast),
        .tick(psc_tick)
    );

    assign baud_mode = regs_q.ctrl.rx_baud | regs_q.ctrl.tx_baud;
    assign cnt_step  = regs_q.ctrl.run & (regs_q.ctrl.src_pin ? cnt_fall : psc_tick);

    cr_count_core #(.W(W)) u_core (
        .clk(clk), .rst_n(rst_n),
        .step(cnt_step),
        .cap_sel(regs_q.ctrl.cap_sel),
        .trig_en(regs_q.ctrl.trig_en),
        .baud(baud_mode),
        .down_en(regs_q.mode.down_en),
        .dir_up(trig_lvl),
        .trig_fall(trig_fall),
        .wr_cnt_lo(wr_cnt_lo), .wr_cnt_hi(wr_cnt_hi),
        .wr_cap_lo(wr_cap_lo), .wr_cap_hi(wr_cap_hi),
        .wdata(wdata),
        .cnt(cnt_val), .cap(cap_val),
        .ovf_set(ovf_set), .ext_set(ext_set),
        .baud_pulse(baud_tick)
    );

    always_comb begin
        regs_d = regs_q;
        if (wr_ctrl) regs_d.ctrl = ctrl_t'(wdata);
        if (wr_mode) regs_d.mode = mode_t'(wdata[1:0]);
        if (ovf_set) regs_d.ctrl.ovf_flag = 1'b1;
        if (ext_set) regs_d.ctrl.ext_flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    always_comb begin
        unique case (ra)
            RA_CTRL:   rdata = regs_q.ctrl;
            RA_MODE:   rdata = {6'd0, regs_q.mode};
            RA_CNT_LO: rdata = cnt_val[7:0];
            RA_CNT_HI: rdata = cnt_val[W-1:8];
            RA_CAP_LO: rdata = cap_val[7:0];
            RA_CAP_HI: rdata = cap_val[W-1:8];
            default:   rdata = 8'd0;
        endcase
    end

    assign irq       = regs_q.ctrl.ovf_flag | regs_q.ctrl.ext_flag;
    assign tx_use_t2 = regs_q.ctrl.tx_baud;
    assign rx_use_t2 = regs_q.ctrl.rx_baud;
endmodule

// File: rtl/cr_timer16_chk.sv
module cr_timer16_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic [2:0]  addr,
    input logic [7:0]  wdata,
    input logic [7:0]  ctrl,
    input logic [1:0]  mode,
    input logic        step,
    input logic [15:0] cnt,
    input logic [15:0] cap
);
    logic wr_ctrl, wr_cnt, wr_cap, baud;
    assign wr_ctrl = wr_en && (addr == 3'd0);
    assign wr_cnt  = wr_en && (addr == 3'd2 || addr == 3'd3);
    assign wr_cap  = wr_en && (addr == 3'd4 || addr == 3'd5);
    assign baud    = ctrl[5] | ctrl[4];

    assert_stop_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl[2] && !wr_cnt) |=> $stable(cnt));

    assert_wrap_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (step && cnt == 16'hFFFF && ctrl[0] && !baud && !mode[0] && !wr_cnt) |=> (cnt == 16'h0000));

    assert_trig_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl[3] && !wr_cap) |=> $stable(cap));

    assert_baud_no_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (baud && !ctrl[7] && !wr_ctrl) |=> !ctrl[7]);

    assert_flag_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl[7] && ctrl[6] && !wr_ctrl) |=> (ctrl[7] && ctrl[6]));

    assert_write_lo_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 3'd2) |=> (cnt[7:0] == $past(wdata)));
endmodule

bind cr_timer16 cr_timer16_chk u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .ctrl(regs_q.ctrl), .mode(regs_q.mode), .step(cnt_step),
    .cnt(cnt_val), .cap(cap_val)
);

// File: tb/sim_cr_timer16.sv
`timescale 1ns/1ps
module sim_cr_timer16;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] addr = 3'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic       cnt_pin = 1'b0;
    logic       trig_pin = 1'b1;
    logic       irq, baud_tick, tx_use_t2, rx_use_t2;

    int checks = 0;
    int fails  = 0;
    int ticks  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    cr_timer16 u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .cnt_pin(cnt_pin), .trig_pin(trig_pin), .irq(irq),
        .baud_tick(baud_tick), .tx_use_t2(tx_use_t2), .rx_use_t2(rx_use_t2)
    );

    always @(posedge clk) if (baud_tick) ticks <= ticks + 1;

    typedef struct packed {
        logic [15:0] pre;
        logic [15:0] cap;
        logic [7:0]  ctrl;
        logic [7:0]  mode;
        logic [7:0]  np;
        logic        dn;
        logic        trig;
        logic [15:0] ecnt;
        logic [15:0] ecap;
        logic [7:0]  ectrl;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{16'h0010, 16'h0000, 8'h06, 8'h00, 8'd5, 1'b0, 1'b0, 16'h0015, 16'h0000, 8'h06}, // R2 count
        '{16'h0010, 16'h0000, 8'h02, 8'h00, 8'd5, 1'b0, 1'b0, 16'h0010, 16'h0000, 8'h02}, // R2 stopped
        '{16'hFFFE, 16'h0000, 8'h07, 8'h00, 8'd3, 1'b0, 1'b0, 16'h0001, 16'h0000, 8'h87}, // R4 wrap
        '{16'hFFFE, 16'h1234, 8'h06, 8'h00, 8'd3, 1'b0, 1'b0, 16'h1235, 16'h1234, 8'h86}, // R5 reload
        '{16'h0100, 16'hAAAA, 8'h0F, 8'h00, 8'd4, 1'b0, 1'b1, 16'h0104, 16'h0104, 8'h4F}, // R6 capture
        '{16'h0100, 16'hAAAA, 8'h07, 8'h00, 8'd4, 1'b0, 1'b1, 16'h0104, 16'hAAAA, 8'h07}, // R8 ignored
        '{16'h0100, 16'h5000, 8'h0E, 8'h00, 8'd2, 1'b0, 1'b1, 16'h5000, 16'h5000, 8'h4E}, // R7 trig reload
        '{16'hFFFF, 16'h2000, 8'h1F, 8'h00, 8'd1, 1'b0, 1'b1, 16'h2000, 16'h2000, 8'h1F}, // R9 tx baud
        '{16'h0005, 16'h3000, 8'h2E, 8'h00, 8'd2, 1'b0, 1'b1, 16'h0007, 16'h3000, 8'h2E}, // R9 rx baud
        '{16'h0005, 16'h0003, 8'h06, 8'h01, 8'd3, 1'b1, 1'b0, 16'hFFFF, 16'h0003, 8'h86}, // R10 down
        '{16'hFFFF, 16'h0003, 8'h06, 8'h01, 8'd1, 1'b0, 1'b0, 16'h0003, 16'h0003, 8'h86}  // R10 up
    };
    localparam string TAGS [NV] = '{"R2", "R2", "R4", "R5", "R6", "R8", "R7", "R9", "R9", "R10", "R10"};

    task automatic chk(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic rd16(input logic [2:0] a, output logic [15:0] d);
        logic [7:0] lo, hi;
        rd(a, lo);
        rd(a + 3'd1, hi);
        d = {hi, lo};
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulses(input int n);
        for (int k = 0; k < n; k++) begin
            cnt_pin = 1'b1; idle(3);
            cnt_pin = 1'b0; idle(3);
        end
        idle(4);
    endtask

    task automatic setup(input logic [15:0] pre, input logic [15:0] cp, input logic [7:0] md, input logic [7:0] ct);
        wr(3'd0, 8'h00);
        wr(3'd1, md);
        wr(3'd2, pre[7:0]);
        wr(3'd3, pre[15:8]);
        wr(3'd4, cp[7:0]);
        wr(3'd5, cp[15:8]);
        wr(3'd0, ct);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0]  b;
        logic [15:0] v;
        int          t0;

        idle(3);
        // R1: reset state
        for (int a = 0; a < 6; a++) begin
            rd(3'(a), b);
            chk("R1", "reset reg", {8'd0, b}, 16'h0000);
        end
        chk("R1", "reset irq", {15'd0, irq}, 16'h0000);
        rst_n = 1'b1;
        idle(4);

        // stimulus table
        for (int i = 0; i < NV; i++) begin
            setup(VECS[i].pre, VECS[i].cap, VECS[i].mode, VECS[i].ctrl);
            if (VECS[i].dn) begin
                trig_pin = 1'b0; idle(4);
            end
            pulses(int'(VECS[i].np));
            if (VECS[i].trig) begin
                trig_pin = 1'b0; idle(3);
                trig_pin = 1'b1; idle(4);
            end
            rd16(3'd2, v); chk(TAGS[i], "count", v, VECS[i].ecnt);
            rd16(3'd4, v); chk(TAGS[i], "capture", v, VECS[i].ecap);
            rd(3'd0, b);   chk(TAGS[i], "control", {8'd0, b}, {8'd0, VECS[i].ectrl});
            trig_pin = 1'b1; idle(4);
        end

        // R3: internal tick, slow and fast
        setup(16'h0000, 16'h0000, 8'h00, 8'h04);
        idle(126);
        rd16(3'd2, v); chk("R3", "slow tick count", v, 16'd10);
        setup(16'h0000, 16'h0000, 8'h02, 8'h04);
        idle(63);
        rd16(3'd2, v); chk("R3", "fast tick count", v, 16'd10);

        // R12: write overrides a running counter
        wr(3'd3, 8'h40);
        wr(3'd2, 8'h00);
        rd(3'd2, b); chk("R12", "low byte after write", {8'd0, b}, 16'h0000);
        rd(3'd3, b); chk("R12", "high byte after write", {8'd0, b}, 16'h0040);

        // R11: flags sticky, irq, software clear
        setup(16'hFFFF, 16'h0000, 8'h00, 8'h06);
        pulses(1);
        rd(3'd0, b); chk("R11", "flag set", {8'd0, b}, 16'h0086);
        chk("R11", "irq high", {15'd0, irq}, 16'h0001);
        idle(20);
        rd(3'd0, b); chk("R11", "flag held", {8'd0, b}, 16'h0086);
        wr(3'd0, 8'h06);
        rd(3'd0, b); chk("R11", "flag cleared", {8'd0, b}, 16'h0006);
        chk("R11", "irq low", {15'd0, irq}, 16'h0000);

        // R9: baud overflow pulses and clock selects
        setup(16'hFFFE, 16'hFFFE, 8'h00, 8'h16);
        t0 = ticks;
        pulses(4);
        chk("R9", "baud pulses", 16'(ticks - t0), 16'd2);
        rd(3'd0, b); chk("R9", "no overflow flag", {8'd0, b}, 16'h0016);
        chk("R9", "irq quiet", {15'd0, irq}, 16'h0000);
        chk("R9", "tx select", {14'd0, tx_use_t2, rx_use_t2}, 16'h0002);
        wr(3'd0, 8'h24);
        chk("R9", "rx select", {14'd0, tx_use_t2, rx_use_t2}, 16'h0001);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule